// File: doc/BRIEF.md
# Scan-Configured Routing Switch Box

This block is one routing node of a reconfigurable array. It carries four 8-bit neighbour input ports and one 8-bit input from the local processing element. It drives four 8-bit neighbour output ports and one 8-bit output back to the processing element. Each of the five outputs is a multiplexer. A per-output connectivity row, fixed at elaboration, names the inputs that output may reach. The multiplexer's select field is only as wide as that allowed set needs.

All select fields sit end to end in a single configuration path. A shadow copy of that path is loaded serially, one bit per clock, while the multiplexers keep running on the active copy. A one-cycle commit pulse copies the shadow path into the active registers. For context save, a capture pulse copies the active selects back into the shadow path so they can be shifted out serially.

Top module: `route_switch_box`

## Requirements
- R1: Synchronous active-high reset clears both the shadow and the active select registers. After reset every output drives the lowest-numbered input its row allows, and scan_out is 0.
- R2: Candidate input j is neighbour lane j (bits 8j+7..8j of nbr_in) for j = 0..3, and the processing-element input for j = 4. Output k is neighbour lane k of nbr_out for k = 0..3, and pe_out for k = 4. The default rows are: output 0 may use inputs {1,2,3,4}, output 1 {0,2,3,4}, output 2 {0,1,3,4}, output 3 {0,1,2}, and output 4 {0,1}.
- R3: A select value s picks the s-th allowed input, counted in ascending index order from 0. A field is ceil(log2(n)) bits wide for n allowed inputs, and at least 1 bit. With the default rows the widths are 2,2,2,2,1.
- R4: When a select value is not below the number of allowed inputs, the output drives all zeros. An example is value 3 on output 3.
- R5: While shift is high and capture is low, the shadow path moves one place toward bit 0 on each clock. scan_in enters the top bit and scan_out always shows bit 0. Field k starts at the sum of the widths of fields 0..k-1, so the default path is 9 bits long. The first bit shifted in ends at bit 0.
- R6: Shifting and capturing never change the data outputs. Only a commit does.
- R7: A commit pulse copies the shadow path into the active selects at the clock edge where it is sampled. The outputs follow the new selects from that edge on.
- R8: A capture pulse copies the active selects into the shadow path. When shift is also high in the same cycle, the capture wins and no shift takes place.
- R9: With shift and capture both low, the shadow path holds its contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| nbr_in | input | 32 | Four neighbour input lanes, lane j at bits 8j+7..8j |
| pe_in | input | 8 | Input from the processing element |
| nbr_out | output | 32 | Four neighbour output lanes |
| pe_out | output | 8 | Output to the processing element |
| shift | input | 1 | Shift the shadow path one place |
| scan_in | input | 1 | Serial configuration bit in |
| scan_out | output | 1 | Bit 0 of the shadow path |
| capture | input | 1 | Load active selects into the shadow path |
| commit | input | 1 | Load shadow path into active selects |

## Verification
The hardest state to reach from the ports is a shadow path that holds one context while the active registers hold a different one. In that state the capture-over-shift priority and the hold behaviour become visible. The bench first commits one context. It then shifts a second context into the shadow path without committing it. A readback then shows whether the shadow path kept its contents or was overwritten by capture. A simultaneous capture-and-shift cycle is then issued with scan_in held at 1, so a wrongly taken shift would leave a visible 1 in the top bit.

// File: rtl/sbox_pkg.sv
package sbox_pkg;

    localparam int ADJ_MAX = 1024;

    typedef logic [ADJ_MAX-1:0] adj_vec_t;

    typedef enum logic [1:0] {
        CH_HOLD,
        CH_SHIFT,
        CH_CAPTURE
    } chain_op_t;

    typedef struct packed {
        logic shift;
        logic capture;
        logic commit;
    } scan_ctl_t;

    // number of inputs allowed for output k
    function automatic int row_count(input adj_vec_t adj, input int n_in, input int k);
        int c;
        c = 0;
        for (int j = 0; j < n_in; j++) begin
            if (adj[k*n_in + j]) c++;
        end
        return c;
    endfunction

    function automatic int sel_width(input int n);
        return (n <= 2) ? 1 : $clog2(n);
    endfunction

    function automatic int field_w(input adj_vec_t adj, input int n_in, input int k);
        return sel_width(row_count(adj, n_in, k));
    endfunction

    // bit offset of field k inside the configuration path
    function automatic int field_off(input adj_vec_t adj, input int n_in, input int k);
        int s;
        s = 0;
        for (int i = 0; i < k; i++) begin
            s += field_w(adj, n_in, i);
        end
        return s;
    endfunction

endpackage

// File: rtl/sbox_scan_chain.sv
module sbox_scan_chain
    import sbox_pkg::*;
#(
    parameter int LEN = 9
) (
    input  logic            clk,
    input  logic            rst,
    input  scan_ctl_t       ctl,
    input  logic            scan_in,
    input  logic [LEN-1:0]  load_val,
    output logic [LEN-1:0]  chain,
    output logic            scan_out
);

    chain_op_t      op;
    logic [LEN-1:0] shifted;

    always_comb begin
        if (ctl.capture)    op = CH_CAPTURE;
        else if (ctl.shift) op = CH_SHIFT;
        else                op = CH_HOLD;
    end

    always_comb begin
        shifted          = chain >> 1;
        shifted[LEN-1]   = scan_in;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            chain <= '0;
        end else begin
            case (op)
                CH_CAPTURE: chain <= load_val;
                CH_SHIFT:   chain <= shifted;
                default:    chain <= chain;
            endcase
        end
    end

    assign scan_out = chain[0];

endmodule

// File: rtl/sbox_active_cfg.sv
module sbox_active_cfg #(
    parameter int LEN = 9
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            commit,
    input  logic [LEN-1:0]  shadow,
    output logic [LEN-1:0]  active
);

    always_ff @(posedge clk) begin
        if (rst)         active <= '0;
        else if (commit) active <= shadow;
    end

endmodule

// File: rtl/sbox_out_mux.sv
module sbox_out_mux #(
    parameter int              N_IN   = 5,
    parameter int              DATA_W = 8,
    parameter logic [N_IN-1:0] ROW    = '1,
    parameter int              SEL_W  = 3
) (
    input  logic [N_IN*DATA_W-1:0] din,
    input  logic [SEL_W-1:0]       sel,
    output logic [DATA_W-1:0]      dout
);

    // rank-encoded select: value s takes the s-th permitted input
    always_comb begin
        int rank;
        rank = 0;
        dout = '0;
        for (int j = 0; j < N_IN; j++) begin
            if (ROW[j]) begin
                if (rank == int'(sel)) dout = din[j*DATA_W +: DATA_W];
                rank++;
            end
        end
    end

endmodule

// File: rtl/route_switch_box.sv
module route_switch_box
    import sbox_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int NBR    = 4,
    parameter logic [(NBR+1)*(NBR+1)-1:0] ADJ = 25'b0001100111110111110111110
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic [NBR*DATA_W-1:0] nbr_in,
    input  logic [DATA_W-1:0]     pe_in,
    output logic [NBR*DATA_W-1:0] nbr_out,
    output logic [DATA_W-1:0]     pe_out,
    input  logic                  shift,
    input  logic                  scan_in,
    output logic                  scan_out,
    input  logic                  capture,
    input  logic                  commit
);

    localparam int N_IN    = NBR + 1;
    localparam int N_OUT   = NBR + 1;
    localparam int CFG_LEN = field_off(adj_vec_t'(ADJ), N_IN, N_OUT);

    logic [N_IN*DATA_W-1:0]  all_in;
    logic [N_OUT*DATA_W-1:0] all_out;
    logic [CFG_LEN-1:0]      shadow;
    logic [CFG_LEN-1:0]      active;
    scan_ctl_t               ctl;

    assign all_in  = {pe_in, nbr_in};
    assign nbr_out = all_out[NBR*DATA_W-1:0];
    assign pe_out  = all_out[N_OUT*DATA_W-1 -: DATA_W];

    assign ctl.shift   = shift;
    assign ctl.capture = capture;
    assign ctl.commit  = commit;

    sbox_scan_chain #(.LEN(CFG_LEN)) u_chain (
        .clk      (clk),
        .rst      (rst),
        .ctl      (ctl),
        .scan_in  (scan_in),
        .load_val (active),
        .chain    (shadow),
        .scan_out (scan_out)
    );

    sbox_active_cfg #(.LEN(CFG_LEN)) u_active (
        .clk    (clk),
        .rst    (rst),
        .commit (ctl.commit),
        .shadow (shadow),
        .active (active)
    );

    for (genvar k = 0; k < N_OUT; k++) begin : g_out
        localparam int              FW  = field_w(adj_vec_t'(ADJ), N_IN, k);
        localparam int              FO  = field_off(adj_vec_t'(ADJ), N_IN, k);
        localparam logic [N_IN-1:0] ROW = ADJ[k*N_IN +: N_IN];

        sbox_out_mux #(
            .N_IN   (N_IN),
            .DATA_W (DATA_W),
            .ROW    (ROW),
            .SEL_W  (FW)
        ) u_mux (
            .din  (all_in),
            .sel  (active[FO +: FW]),
            .dout (all_out[k*DATA_W +: DATA_W])
        );
    end

endmodule

// File: rtl/route_switch_box_chk.sv
module route_switch_box_chk #(
    parameter int CFG_LEN = 9,
    parameter int DATA_W  = 8,
    parameter int NBR     = 4
) (
    input logic                  clk,
    input logic                  rst,
    input logic                  shift,
    input logic                  capture,
    input logic                  commit,
    input logic                  scan_out,
    input logic [CFG_LEN-1:0]    shadow,
    input logic [CFG_LEN-1:0]    active,
    input logic [NBR*DATA_W-1:0] nbr_in,
    input logic [DATA_W-1:0]     pe_in,
    input logic [NBR*DATA_W-1:0] nbr_out,
    input logic [DATA_W-1:0]     pe_out
);

    a_r9_shadow_hold: assert property (@(posedge clk) disable iff (rst)
        (!shift && !capture) |=> $stable(shadow));

    a_r8_capture_load: assert property (@(posedge clk) disable iff (rst)
        capture |=> (shadow == $past(active)));

    a_r7_commit_load: assert property (@(posedge clk) disable iff (rst)
        commit |=> (active == $past(shadow)));

    a_r6_active_hold: assert property (@(posedge clk) disable iff (rst)
        !commit |=> $stable(active));

    a_r6_outputs_steady: assert property (@(posedge clk) disable iff (rst)
        ($stable(active) && $stable(nbr_in) && $stable(pe_in))
            |-> ($stable(nbr_out) && $stable(pe_out)));

    if (CFG_LEN > 1) begin : g_shift_chk
        a_r5_shift_out: assert property (@(posedge clk) disable iff (rst)
            (shift && !capture) |=> (scan_out == $past(shadow[1])));
    end

endmodule

bind route_switch_box route_switch_box_chk #(
    .CFG_LEN (CFG_LEN),
    .DATA_W  (DATA_W),
    .NBR     (NBR)
) u_chk (.*);

// File: tb/route_switch_box_bench.sv
`timescale 1ns/1ps
module route_switch_box_bench;

    localparam int LEN = 9;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] nbr_in = '0;
    logic [7:0]  pe_in = '0;
    logic [31:0] nbr_out;
    logic [7:0]  pe_out;
    logic        shift = 1'b0;
    logic        scan_in = 1'b0;
    logic        scan_out;
    logic        capture = 1'b0;
    logic        commit = 1'b0;

    int n_checks = 0;
    int n_fail   = 0;

    always #2.5 clk = ~clk;

    route_switch_box u_route_switch_box (
        .clk(clk), .rst(rst), .nbr_in(nbr_in), .pe_in(pe_in),
        .nbr_out(nbr_out), .pe_out(pe_out), .shift(shift),
        .scan_in(scan_in), .scan_out(scan_out),
        .capture(capture), .commit(commit)
    );

    // allowed-input rows and field layout as stated in R2, R3, R5
    function automatic logic [4:0] row_of(input int k);
        case (k)
            0: return 5'b11110;
            1: return 5'b11101;
            2: return 5'b11011;
            3: return 5'b00111;
            default: return 5'b00011;
        endcase
    endfunction

    function automatic logic [7:0] ref_out(input int k, input logic [LEN-1:0] cfg);
        logic [4:0] row;
        int s, w, off, rank;
        logic [7:0] r;
        row = row_of(k);
        w   = (k == 4) ? 1 : 2;
        off = 2 * k;
        s = 0;
        for (int b = 0; b < w; b++) s += int'(cfg[off+b]) << b;
        r = '0;
        rank = 0;
        for (int j = 0; j < 5; j++) begin
            if (row[j]) begin
                if (rank == s) r = (j == 4) ? pe_in : nbr_in[8*j +: 8];
                rank++;
            end
        end
        return r;
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic chk_outs(input string req, input logic [LEN-1:0] cfg);
        for (int k = 0; k < 4; k++) chk(req, 32'(nbr_out[8*k +: 8]), 32'(ref_out(k, cfg)));
        chk(req, 32'(pe_out), 32'(ref_out(4, cfg)));
    endtask

    task automatic shift_vec(input logic [LEN-1:0] v);
        for (int i = 0; i < LEN; i++) begin
            @(negedge clk);
            shift = 1'b1;
            scan_in = v[i];
        end
        @(negedge clk);
        shift = 1'b0;
        scan_in = 1'b0;
    endtask

    task automatic read_vec(output logic [LEN-1:0] v);
        for (int i = 0; i < LEN; i++) begin
            v[i] = scan_out;
            shift = 1'b1;
            @(negedge clk);
        end
        shift = 1'b0;
    endtask

    task automatic pulse_commit();
        commit = 1'b1;
        @(negedge clk);
        commit = 1'b0;
    endtask

    localparam logic [LEN-1:0] V1 = 9'b1_01_10_00_11;
    localparam logic [LEN-1:0] V2 = 9'b0_11_01_11_00;

    task automatic t_reset();
        chk("R1 scan_out after reset", 32'(scan_out), 32'd0);
        chk_outs("R1 reset selects", '0);
    endtask

    task automatic t_load_commit();
        shift_vec(V1);
        chk_outs("R6 shifted but not committed", '0);
        commit = 1'b1;
        chk_outs("R7 before commit edge", '0);
        @(negedge clk);
        commit = 1'b0;
        chk_outs("R7 R3 after commit", V1);
    endtask

    task automatic t_patterns();
        nbr_in = 32'hA5_C3_0F_F0;
        pe_in  = 8'h99;
        #1 chk_outs("R2 second data pattern", V1);
        nbr_in = 32'h01_02_04_08;
        pe_in  = 8'h80;
        #1 chk_outs("R2 third data pattern", V1);
        nbr_in = 32'h44_33_22_11;
        pe_in  = 8'h55;
        @(negedge clk);
    endtask

    task automatic t_beyond();
        shift_vec(V2);
        pulse_commit();
        chk("R4 out3 select past allowed set", 32'(nbr_out[31:24]), 32'd0);
        chk_outs("R4 R3 other outputs", V2);
    endtask

    task automatic t_capture();
        logic [LEN-1:0] got;
        shift_vec(V1);
        capture = 1'b1;
        @(negedge clk);
        capture = 1'b0;
        chk_outs("R6 capture leaves outputs", V2);
        read_vec(got);
        chk("R8 R5 readback of active", 32'(got), 32'(V2));
    endtask

    task automatic t_priority();
        logic [LEN-1:0] got;
        shift_vec(V1);
        capture = 1'b1;
        shift   = 1'b1;
        scan_in = 1'b1;
        @(negedge clk);
        capture = 1'b0;
        shift   = 1'b0;
        scan_in = 1'b0;
        read_vec(got);
        chk("R8 capture wins over shift", 32'(got), 32'(V2));
    endtask

    task automatic t_hold();
        logic [LEN-1:0] got;
        shift_vec(V1);
        for (int i = 0; i < 5; i++) begin
            @(negedge clk);
            chk("R9 idle scan_out", 32'(scan_out), 32'(V1[0]));
        end
        read_vec(got);
        chk("R9 R5 shadow kept", 32'(got), 32'(V1));
        chk_outs("R6 outputs without commit", V2);
    endtask

    initial begin
        nbr_in = 32'h44_33_22_11;
        pe_in  = 8'h55;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_load_commit();
        t_patterns();
        t_beyond();
        t_capture();
        t_priority();
        t_hold();
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

    initial begin
        #(200000 * 5);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

endmodule